// File: doc/BRIEF.md
# Dual-Flag Write-Protect Controller

This block sits beside the serial front end of a 256-byte non-volatile memory and decides whether each memory write may land. It keeps two lower-half protection flags: a one-time flag that can only be set, and a second flag that can be set and cleared again. Both cover addresses 00h to 7Fh. A hardware protect input, when high, blocks writes to every address whatever the flags hold.

The front end hands over each decoded control byte together with the device-select pin levels and a digital qualifier that stands in for a high-voltage level on select pin 0. The block classifies the byte as a memory access, a protect-flag program command or a protect-flag status query. One cycle later it returns whether the byte is to be acknowledged. A program command that was acknowledged waits for a commit pulse, which the front end raises at the stop condition. The flag changes only at that pulse. The flags sit in their own registers that the ordinary reset leaves alone. A separate power-on clear input sets them to a known state.

Top module: `wprot_ctrl`

## Requirements
- R1: While `prot_pin` is high, `wr_allow` is 0 for every `wr_addr`, whatever the flag states.
- R2: While `prot_pin` is low, `wr_allow` is 0 when `wr_addr[7]` is 0 and at least one flag is set. It is 1 in every other case. `wr_allow` is combinational in `wr_addr`.
- R3: A control byte with upper nibble 1010 whose bits [3:1] equal `dev_sel` is acknowledged whatever the flags or `prot_pin`. A 1010 byte with non-matching bits [3:1] is not acknowledged, and neither is any upper nibble other than 1010 or 0110.
- R4: With `hv_a0` low, the byte 0110 followed by `dev_sel` in bits [3:1] and bit 0 equal to 0 is the one-time set command. If acknowledged and committed, it sets the one-time flag. Once set, that flag is never cleared by commands, by commits or by `rst`.
- R5: While the one-time flag is set, every byte with upper nibble 0110 is not acknowledged, the clear command included.
- R6: With `hv_a0` high, byte 8'h62 with `dev_sel[2:1]`=00 is the set command for the reversible flag. Byte 8'h66 with `dev_sel[2:1]`=01 is its clear command. A set command is not acknowledged while the reversible flag is already set. A clear command is acknowledged whenever the one-time flag is clear. A committed command changes the flag.
- R7: A 0110 byte with bit 0 equal to 1 is a status query. With `hv_a0` low and bits [3:1] equal to `dev_sel`, it queries the one-time flag. With `hv_a0` high and a reversible pattern (8'h63 or 8'h67 with the matching `dev_sel[2:1]`), it queries the reversible flag. It is acknowledged exactly when the queried flag is clear, and it changes no state.
- R8: A commit taken while `prot_pin` is high changes neither flag. Acknowledge decisions do not depend on `prot_pin`.
- R9: `ack_vld` is high in exactly the cycle after a `ctrl_vld` cycle. `ack_ctrl` carries the decision for that byte, judged on the flag values before that edge.
- R10: `rst` clears `ack_vld`, `ack_ctrl` and any waiting command but keeps both flags. `por_clr` clears both flags.
- R11: A commit with no acknowledged program command waiting has no effect. An unmatched 0110 pattern, such as 8'h62 with `hv_a0` high and the wrong `dev_sel`, is not acknowledged and is never applied.
- R12: When `cmd_commit` and `ctrl_vld` fall in the same cycle, the command that was already waiting is applied. The new byte is judged on the flags before that edge and becomes the waiting command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; flags preserved |
| por_clr | input | 1 | Synchronous power-on clear of both flags |
| ctrl_vld | input | 1 | A decoded control byte is present this cycle |
| ctrl_byte | input | 8 | Control byte, bit 0 is read/write select |
| dev_sel | input | 3 | Logic levels of the three device-select pins |
| hv_a0 | input | 1 | High-voltage qualifier on select pin 0 |
| prot_pin | input | 1 | Hardware protect level |
| cmd_commit | input | 1 | Stop condition seen, apply waiting program command |
| wr_addr | input | 8 | Address of the memory write being judged |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_ctrl | output | 1 | 1 = acknowledge the control byte |
| wr_allow | output | 1 | 1 = the write to `wr_addr` may proceed |

## Verification
The commit of a waiting program command and the decode of a new control byte can land on the same clock edge. Both read the flags and one of them changes them. The bench first leaves a set command for the reversible flag waiting. It then raises `cmd_commit` together with a status query of that flag. The query must be acknowledged, because it sees the flag before the edge. A second query afterwards must not be acknowledged, and a lower-half write must then be refused, which shows the commit took effect.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam logic [3:0] PRE_MEM  = 4'b1010;
  localparam logic [3:0] PRE_PROT = 4'b0110;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_MEM,
    CK_SET_PERM,
    CK_RD_PERM,
    CK_SET_REV,
    CK_CLR_REV,
    CK_RD_REV
  } cmd_kind_t;

  function automatic logic is_program(cmd_kind_t k);
    return (k == CK_SET_PERM) || (k == CK_SET_REV) || (k == CK_CLR_REV);
  endfunction

endpackage

// File: rtl/wprot_cmd_decode.sv
module wprot_cmd_decode
  import wprot_pkg::*;
#(
  parameter int DEV_W = 3
) (
  input  logic [DEV_W+4:0] ctrl_byte,
  input  logic [DEV_W-1:0] dev_sel,
  input  logic             hv_a0,
  output cmd_kind_t        kind
);
  localparam int BYTE_W = DEV_W + 5;

  logic [3:0]       pre;
  logic [DEV_W-1:0] sel;
  logic             rd;
  logic             rev_set_pat;
  logic             rev_clr_pat;

  assign pre = ctrl_byte[BYTE_W-1:BYTE_W-4];
  assign sel = ctrl_byte[DEV_W:1];
  assign rd  = ctrl_byte[0];

  // reversible-flag patterns: select bits in the byte mirror the pins,
  // with pin 0 held at the high-voltage level (logic 1)
  assign rev_set_pat = (dev_sel[DEV_W-1:1] == '0) &&
                       (sel == {{(DEV_W-1){1'b0}}, 1'b1});
  assign rev_clr_pat = (dev_sel[DEV_W-1:1] == {{(DEV_W-2){1'b0}}, 1'b1}) &&
                       (sel == {{(DEV_W-2){1'b0}}, 2'b11});

  always_comb begin
    kind = CK_NONE;
    if (pre == PRE_MEM) begin
      if (sel == dev_sel) kind = CK_MEM;
    end else if (pre == PRE_PROT) begin
      if (hv_a0) begin
        if (rev_set_pat)      kind = rd ? CK_RD_REV : CK_SET_REV;
        else if (rev_clr_pat) kind = rd ? CK_RD_REV : CK_CLR_REV;
      end else if (sel == dev_sel) begin
        kind = rd ? CK_RD_PERM : CK_SET_PERM;
      end
    end
  end
endmodule

// File: rtl/wprot_flag_store.sv
module wprot_flag_store
  import wprot_pkg::*;
#(
  parameter bit RST_CLEARS_FLAGS = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      por_clr,
  input  logic      ctrl_vld,
  input  cmd_kind_t kind,
  input  logic      prot_pin,
  input  logic      cmd_commit,
  output logic      perm_q,
  output logic      rev_q,
  output logic      ack_vld,
  output logic      ack_ctrl
);
  logic      flag_clr;
  logic      ack_d;
  cmd_kind_t pend_q;
  logic      apply;

  generate
    if (RST_CLEARS_FLAGS) begin : g_volatile
      assign flag_clr = rst | por_clr;
    end else begin : g_preserve
      assign flag_clr = por_clr;
    end
  endgenerate

  always_comb begin
    unique case (kind)
      CK_MEM:      ack_d = 1'b1;
      CK_SET_PERM: ack_d = !perm_q;
      CK_RD_PERM:  ack_d = !perm_q;
      CK_SET_REV:  ack_d = !perm_q && !rev_q;
      CK_RD_REV:   ack_d = !perm_q && !rev_q;
      CK_CLR_REV:  ack_d = !perm_q;
      default:     ack_d = 1'b0;
    endcase
  end

  assign apply = cmd_commit && !prot_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_vld  <= 1'b0;
      ack_ctrl <= 1'b0;
      pend_q   <= CK_NONE;
    end else begin
      ack_vld  <= ctrl_vld;
      ack_ctrl <= ctrl_vld && ack_d;
      if (ctrl_vld)
        pend_q <= (ack_d && is_program(kind)) ? kind : CK_NONE;
      else if (cmd_commit)
        pend_q <= CK_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (flag_clr) begin
      perm_q <= 1'b0;
    end else if (apply && pend_q == CK_SET_PERM) begin
      perm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (flag_clr) begin
      rev_q <= 1'b0;
    end else if (apply && pend_q == CK_SET_REV) begin
      rev_q <= 1'b1;
    end else if (apply && pend_q == CK_CLR_REV) begin
      rev_q <= 1'b0;
    end
  end

  // R4: one-time flag only falls through the power-on clear
  p_perm_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (perm_q && !por_clr) |=> perm_q);

  // R8: a commit under the protect pin leaves both flags alone
  p_pin_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_commit && prot_pin && !por_clr) |=> ($stable(perm_q) && $stable(rev_q)));

  // R9: decision valid exactly one cycle after the byte
  p_ack_timing_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_vld |=> ack_vld);
  p_ack_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_vld |=> !ack_vld);
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              prot_pin,
  input  logic              perm_q,
  input  logic              rev_q,
  output logic              wr_allow
);
  localparam int HALF_BIT = ADDR_W - 1;

  logic upper_half;
  logic soft_lock;

  assign upper_half = wr_addr[HALF_BIT];
  assign soft_lock  = perm_q | rev_q;
  assign wr_allow   = !prot_pin && (upper_half || !soft_lock);
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W           = 8,
  parameter int DEV_W            = 3,
  parameter bit RST_CLEARS_FLAGS = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_clr,
  input  logic              ctrl_vld,
  input  logic [DEV_W+4:0]  ctrl_byte,
  input  logic [DEV_W-1:0]  dev_sel,
  input  logic              hv_a0,
  input  logic              prot_pin,
  input  logic              cmd_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ack_vld,
  output logic              ack_ctrl,
  output logic              wr_allow
);
  cmd_kind_t kind;
  logic      perm_q;
  logic      rev_q;

  wprot_cmd_decode #(.DEV_W(DEV_W)) u_dec (
    .ctrl_byte (ctrl_byte),
    .dev_sel   (dev_sel),
    .hv_a0     (hv_a0),
    .kind      (kind)
  );

  wprot_flag_store #(.RST_CLEARS_FLAGS(RST_CLEARS_FLAGS)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .por_clr    (por_clr),
    .ctrl_vld   (ctrl_vld),
    .kind       (kind),
    .prot_pin   (prot_pin),
    .cmd_commit (cmd_commit),
    .perm_q     (perm_q),
    .rev_q      (rev_q),
    .ack_vld    (ack_vld),
    .ack_ctrl   (ack_ctrl)
  );

  wprot_gate #(.ADDR_W(ADDR_W)) u_gate (
    .wr_addr  (wr_addr),
    .prot_pin (prot_pin),
    .perm_q   (perm_q),
    .rev_q    (rev_q),
    .wr_allow (wr_allow)
  );

  // R1: hardware pin wins over everything
  p_pin_blocks_r1: assert property (@(posedge clk) disable iff (rst || por_clr)
    prot_pin |-> !wr_allow);

  // R2: any soft flag shuts the lower half
  p_lower_half_r2: assert property (@(posedge clk) disable iff (rst || por_clr)
    ((perm_q || rev_q) && !wr_addr[ADDR_W-1]) |-> !wr_allow);

  // R5: one-time flag silences every protect-register byte
  p_perm_nack_r5: assert property (@(posedge clk) disable iff (rst || por_clr)
    (ctrl_vld && perm_q && ctrl_byte[DEV_W+4:DEV_W+1] == PRE_PROT) |=> !ack_ctrl);
endmodule

// File: tb/wprot_ctrl_bench.sv
module wprot_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_clr = 1'b1;
  logic       ctrl_vld = 1'b0;
  logic [7:0] ctrl_byte = 8'h00;
  logic [2:0] dev_sel = 3'b000;
  logic       hv_a0 = 1'b0;
  logic       prot_pin = 1'b0;
  logic       cmd_commit = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic       ack_vld;
  logic       ack_ctrl;
  logic       wr_allow;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  wprot_ctrl u_wprot_ctrl (
    .clk(clk), .rst(rst), .por_clr(por_clr), .ctrl_vld(ctrl_vld),
    .ctrl_byte(ctrl_byte), .dev_sel(dev_sel), .hv_a0(hv_a0),
    .prot_pin(prot_pin), .cmd_commit(cmd_commit), .wr_addr(wr_addr),
    .ack_vld(ack_vld), .ack_ctrl(ack_ctrl), .wr_allow(wr_allow)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // send a byte, optionally with a commit in the same cycle; check decision
  task automatic send(input logic [7:0] b, input logic [2:0] ds, input logic hv,
                      input logic with_commit, input logic exp_ack, input string tag);
    @(negedge clk);
    ctrl_byte = b; dev_sel = ds; hv_a0 = hv;
    ctrl_vld = 1'b1; cmd_commit = with_commit;
    @(negedge clk);
    ctrl_vld = 1'b0; cmd_commit = 1'b0;
    chk(ack_vld, 1'b1, {tag, " R9 ack_vld"});
    chk(ack_ctrl, exp_ack, tag);
  endtask

  task automatic commit();
    @(negedge clk);
    cmd_commit = 1'b1;
    @(negedge clk);
    cmd_commit = 1'b0;
  endtask

  task automatic probe(input logic [7:0] a, input logic exp, input string tag);
    wr_addr = a;
    #1;
    chk(wr_allow, exp, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ack_vld, 1'b0, "R10 ack_vld after reset");
    probe(8'h00, 1'b1, "R2 low half open after clear");
    probe(8'hFF, 1'b1, "R2 high half open after clear");
  endtask

  task automatic t_mem();
    send(8'hAA, 3'b101, 1'b0, 1'b0, 1'b1, "R3 memory byte match");
    @(negedge clk);
    chk(ack_vld, 1'b0, "R9 ack_vld drops");
    send(8'hAB, 3'b101, 1'b0, 1'b0, 1'b1, "R3 memory read match");
    send(8'hA4, 3'b101, 1'b0, 1'b0, 1'b0, "R3 memory select mismatch");
    send(8'h5A, 3'b101, 1'b0, 1'b0, 1'b0, "R3 unknown nibble");
  endtask

  task automatic t_rev();
    send(8'h63, 3'b000, 1'b1, 1'b0, 1'b1, "R7 query rev clear");
    send(8'h62, 3'b000, 1'b1, 1'b0, 1'b1, "R6 set rev ack");
    probe(8'h10, 1'b1, "R6 no change before commit");
    commit();
    probe(8'h10, 1'b0, "R6 rev set blocks low half");
    probe(8'h80, 1'b1, "R2 high half still open");
    send(8'h63, 3'b000, 1'b1, 1'b0, 1'b0, "R7 query rev set");
    send(8'h62, 3'b000, 1'b1, 1'b0, 1'b0, "R6 set rev twice nack");
    commit();
    probe(8'h10, 1'b0, "R11 commit after nack no change");
    send(8'h66, 3'b010, 1'b1, 1'b0, 1'b1, "R6 clear rev ack");
    commit();
    probe(8'h10, 1'b1, "R6 clear rev reopens");
  endtask

  task automatic t_pin();
    prot_pin = 1'b1;
    probe(8'h80, 1'b0, "R1 pin blocks high");
    probe(8'h00, 1'b0, "R1 pin blocks low");
    send(8'hA0, 3'b000, 1'b0, 1'b0, 1'b1, "R3 memory acked under pin");
    send(8'h62, 3'b000, 1'b1, 1'b0, 1'b1, "R8 set rev acked under pin");
    commit();
    prot_pin = 1'b0;
    probe(8'h10, 1'b1, "R8 set under pin no effect");
    send(8'h63, 3'b000, 1'b1, 1'b0, 1'b1, "R8 rev still clear");
  endtask

  task automatic t_bad();
    send(8'h62, 3'b100, 1'b1, 1'b0, 1'b0, "R11 rev pattern wrong pins");
    commit();
    probe(8'h10, 1'b1, "R11 unmatched not applied");
    commit();
    probe(8'h10, 1'b1, "R11 idle commit no effect");
  endtask

  task automatic t_same_cycle();
    send(8'h62, 3'b000, 1'b1, 1'b0, 1'b1, "R12 set rev waiting");
    send(8'h63, 3'b000, 1'b1, 1'b1, 1'b1, "R12 query sees old flag");
    probe(8'h10, 1'b0, "R12 waiting command applied");
    send(8'h63, 3'b000, 1'b1, 1'b0, 1'b0, "R12 query after commit");
  endtask

  task automatic t_rst_keep();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(ack_vld, 1'b0, "R10 rst clears ack_vld");
    probe(8'h10, 1'b0, "R10 rev kept over rst");
    send(8'h66, 3'b010, 1'b1, 1'b0, 1'b1, "R6 clear rev again");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    commit();
    probe(8'h10, 1'b0, "R10 rst drops waiting command");
    send(8'h66, 3'b010, 1'b1, 1'b0, 1'b1, "R6 clear rev retry");
    commit();
    probe(8'h10, 1'b1, "R6 clear rev applied");
  endtask

  task automatic t_perm();
    send(8'h67, 3'b011, 1'b0, 1'b0, 1'b1, "R7 query perm clear");
    send(8'h66, 3'b011, 1'b0, 1'b0, 1'b1, "R4 set perm ack");
    commit();
    probe(8'h05, 1'b0, "R4 perm blocks low half");
    probe(8'hC0, 1'b1, "R2 perm leaves high half");
    send(8'h67, 3'b011, 1'b0, 1'b0, 1'b0, "R5 query perm nack");
    send(8'h66, 3'b010, 1'b1, 1'b0, 1'b0, "R5 clear rev nack under perm");
    send(8'h62, 3'b000, 1'b1, 1'b0, 1'b0, "R5 set rev nack under perm");
    commit();
    send(8'hA6, 3'b011, 1'b0, 1'b0, 1'b1, "R3 memory acked under perm");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    probe(8'h05, 1'b0, "R4 perm survives rst");
    @(negedge clk); por_clr = 1'b1;
    @(negedge clk); por_clr = 1'b0;
    probe(8'h05, 1'b1, "R10 por_clr clears perm");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; por_clr = 1'b0;
    t_reset();
    t_mem();
    t_rev();
    t_pin();
    t_bad();
    t_same_cycle();
    t_rst_keep();
    t_perm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule